// File: doc/BRIEF.md
# PLL start-up and shutdown sequencer

This block owns the control word of one PLL and steps it through its power-up and power-down orderings, so that software never has to poll or time them. An enable request loads the divider and bandwidth factors and powers the PLL. It then gives the PLL's reset a clean low-high-low pulse and polls the lock status. While any lock bit is still low, it pulses a slip-clear strobe. Once lock is seen, it leaves bypass and sets enable. A disable request first bypasses the PLL and only then powers it down.

When the instance drives the CPU's PLL (parameter `IS_CPU`), the block also owns the select of the main bus clock. That clock is moved onto the raw reference before the PLL is disturbed and moved back once the PLL runs. A lock timeout ends a hopeless relock with an error flag and leaves the PLL bypassed and the bus on the raw input.

The reset input is asynchronous and active low; it is synchronised inside the block before use, which adds two cycles of reset latency.

Top module: `pll_seq`

## Requirements
- R1: During and after reset, `ctrl_o` is zero except bypass (bit 23) = 1; `bus_sel_pll_o`, `slip_clr_o`, `busy_o`, `done_o` and `err_o` are 0.
- R2: Control word layout: reference divider in bits 3:0, feedback divider in 9:4, output divider in 13:10, bandwidth adjust in 19:14, reset bit 20, power bit 21, internal feedback bit 22 (held 0), bypass bit 23, test bit 24 (held 0), enable bit 25. The factor inputs are loaded into bits 19:0 together with power-up.
- R3: An accepted enable runs these steps, one clock edge apart unless stated: park the bus select to 0 (CPU instance only); load the factors and set power; clear reset; set reset; hold reset; poll lock; clear bypass and set enable in one write; set bus select to 1 (CPU instance only).
- R4: The reset bit stays high for exactly `RST_HOLD` cycles (`RST_HOLD` >= 2) before release.
- R5: Lock passes only when all `LOCK_W` bits of `lock_i` are 1. Each failed poll produces a one-cycle `slip_clr_o` pulse in the following cycle. Enable never rises unless a complete lock was sampled two cycles earlier.
- R6: An accepted disable sets bypass on the first edge, then clears power and enable on the next; the bus select is not changed.
- R7: An enable request while the PLL counts as enabled (power = 1, enable = 1, reset = 0) is ignored: `busy_o` stays 0 and `ctrl_o` is unchanged.
- R8: `busy_o` is 1 from the cycle after an accepted request through the last cycle of the sequence. `done_o` is 1 for exactly that last cycle.
- R9: After `LOCK_TIMEOUT` polls without lock, `err_o` is set and the sequence ends with `done_o`. The PLL is left powered with bypass set and enable clear, and the bus select stays 0. `err_o` clears when the next request is accepted.
- R10: Requests are accepted only while idle; requests during a sequence are ignored. If enable and disable arrive together, the disable runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_en_i | input | 1 | Request to start the PLL |
| req_dis_i | input | 1 | Request to stop the PLL |
| ref_div_i | input | 4 | Reference divider factor |
| fb_div_i | input | 6 | Feedback divider factor |
| out_div_i | input | 4 | Output divider factor |
| bw_adj_i | input | 6 | Bandwidth adjust factor |
| lock_i | input | LOCK_W | Lock status bits from the PLL |
| ctrl_o | output | 26 | PLL control word |
| slip_clr_o | output | 1 | Slip-clear strobe after a failed lock poll |
| bus_sel_pll_o | output | 1 | Main bus clock select: 1 = PLL, 0 = raw input |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse in the last cycle of a sequence |
| err_o | output | 1 | Last enable ended in a lock timeout |

## Verification
On every cycle, the assertions enforce the following orderings:
- the reset bit never falls after less than two high cycles;
- power never drops unless bypass was already set;
- a slip strobe only follows a partial lock;
- enable rises only after a full lock, and only while the bus is parked;
- done lasts a single cycle.

The exact step spacing, the factor bit placement, and the ignoring of requests while busy or already enabled can only be shown by the bench's scenarios. The same holds for disable winning over enable, and for the error path and its clearing on the next request. These scenarios run against a PLL model whose two lock bits rise at different times and which can be made never to lock.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  // control word layout; neighbours decode these positions
  localparam int REF_LSB = 0;
  localparam int REF_W   = 4;
  localparam int FB_LSB  = 4;
  localparam int FB_W    = 6;
  localparam int OD_LSB  = 10;
  localparam int OD_W    = 4;
  localparam int BW_LSB  = 14;
  localparam int BW_W    = 6;
  localparam int FACT_W  = REF_W + FB_W + OD_W + BW_W;
  localparam int BIT_RST = 20;
  localparam int BIT_PWR = 21;
  localparam int BIT_IFB = 22;
  localparam int BIT_BYP = 23;
  localparam int BIT_TST = 24;
  localparam int BIT_EN  = 25;
  localparam int CTRL_W  = 26;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PARK, ST_PROG, ST_RLOW, ST_RSET, ST_RHOLD,
    ST_POLL, ST_RUN, ST_UNPARK, ST_BYP, ST_OFF, ST_FIN
  } seq_state_t;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_PARK, CMD_PROG, CMD_RST_LO, CMD_RST_HI,
    CMD_SLIP, CMD_RUN, CMD_UNPARK, CMD_BYPASS, CMD_OFF
  } seq_cmd_t;
endpackage

// File: rtl/pll_seq_cnt.sv
module pll_seq_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int LOCK_W       = 2,
  parameter int RST_HOLD     = 2,
  parameter int LOCK_TIMEOUT = 1000,
  parameter int CNT_W        = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_en_i,
  input  logic              req_dis_i,
  input  logic              pll_on_i,
  input  logic [LOCK_W-1:0] lock_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output seq_cmd_t          cmd_o,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RST_HOLD - 1);
  localparam logic [CNT_W-1:0] POLL_LAST = CNT_W'(LOCK_TIMEOUT - 1);

  seq_state_t state_q, state_d;
  logic       err_q, err_d, err_en;
  logic       accept, timeout;

  always_comb begin
    state_d   = state_q;
    cmd_o     = CMD_NONE;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    timeout   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_clr_o = 1'b1;
        if (req_dis_i)                 state_d = ST_BYP;
        else if (req_en_i && !pll_on_i) state_d = ST_PARK;
      end
      ST_PARK:   begin cmd_o = CMD_PARK;   state_d = ST_PROG; end
      ST_PROG:   begin cmd_o = CMD_PROG;   state_d = ST_RLOW; end
      ST_RLOW:   begin cmd_o = CMD_RST_LO; state_d = ST_RSET; end
      ST_RSET: begin
        cmd_o     = CMD_RST_HI;
        cnt_clr_o = 1'b1;
        state_d   = ST_RHOLD;
      end
      ST_RHOLD: begin
        if (cnt_i == HOLD_LAST) begin
          cmd_o     = CMD_RST_LO;
          cnt_clr_o = 1'b1;
          state_d   = ST_POLL;
        end else begin
          cnt_inc_o = 1'b1;
        end
      end
      ST_POLL: begin
        if (&lock_i) begin
          state_d = ST_RUN;
        end else if (cnt_i == POLL_LAST) begin
          timeout = 1'b1;
          state_d = ST_FIN;
        end else begin
          cmd_o     = CMD_SLIP;
          cnt_inc_o = 1'b1;
        end
      end
      ST_RUN:    begin cmd_o = CMD_RUN;    state_d = ST_UNPARK; end
      ST_UNPARK: begin cmd_o = CMD_UNPARK; state_d = ST_FIN; end
      ST_BYP:    begin cmd_o = CMD_BYPASS; state_d = ST_OFF; end
      ST_OFF:    begin cmd_o = CMD_OFF;    state_d = ST_FIN; end
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    accept = (state_q == ST_IDLE) && (state_d != ST_IDLE);
    err_en = accept | timeout;
    err_d  = timeout;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIN);
  assign err_o  = err_q;

  // R8: the completion strobe never lasts two cycles
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10: a new sequence starts only from idle
  a_r10_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_en_i || req_dis_i));
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter bit IS_CPU = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_cmd_t          cmd_i,
  input  logic [FACT_W-1:0] fact_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              bus_sel_o,
  output logic              slip_o
);
  localparam logic [CTRL_W-1:0] CTRL_INIT = CTRL_W'(1) << BIT_BYP;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;
  logic              slip_q;

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_en = 1'b1;
    unique case (cmd_i)
      CMD_PROG: begin
        ctrl_d[FACT_W-1:0] = fact_i;
        ctrl_d[BIT_PWR]    = 1'b1;
      end
      CMD_RST_LO: ctrl_d[BIT_RST] = 1'b0;
      CMD_RST_HI: ctrl_d[BIT_RST] = 1'b1;
      CMD_RUN: begin
        ctrl_d[BIT_BYP] = 1'b0;
        ctrl_d[BIT_EN]  = 1'b1;
      end
      CMD_BYPASS: ctrl_d[BIT_BYP] = 1'b1;
      CMD_OFF: begin
        ctrl_d[BIT_PWR] = 1'b0;
        ctrl_d[BIT_EN]  = 1'b0;
      end
      default: ctrl_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= CTRL_INIT;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slip_q <= 1'b0;
    else         slip_q <= (cmd_i == CMD_SLIP);
  end

  generate
    if (IS_CPU) begin : g_bus_sel
      logic bus_q, bus_d, bus_en;
      always_comb begin
        bus_en = (cmd_i == CMD_PARK) || (cmd_i == CMD_UNPARK);
        bus_d  = (cmd_i == CMD_UNPARK);
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     bus_q <= 1'b0;
        else if (bus_en) bus_q <= bus_d;
      end
      assign bus_sel_o = bus_q;
    end else begin : g_no_bus_sel
      assign bus_sel_o = 1'b0;
    end
  endgenerate

  assign ctrl_o = ctrl_q;
  assign slip_o = slip_q;

  // R4: reset pulse is at least two cycles wide
  a_r4_rst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q[BIT_RST]) |-> $past(ctrl_q[BIT_RST], 2));
  // R6: power is only removed from a bypassed PLL
  a_r6_bypass_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q[BIT_PWR]) |-> $past(ctrl_q[BIT_BYP]));
endmodule

// File: rtl/pll_seq.sv
module pll_seq
  import pll_seq_pkg::*;
#(
  parameter int LOCK_W       = 2,
  parameter bit IS_CPU       = 1'b1,
  parameter int RST_HOLD     = 2,
  parameter int LOCK_TIMEOUT = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_en_i,
  input  logic              req_dis_i,
  input  logic [3:0]        ref_div_i,
  input  logic [5:0]        fb_div_i,
  input  logic [3:0]        out_div_i,
  input  logic [5:0]        bw_adj_i,
  input  logic [LOCK_W-1:0] lock_i,
  output logic [25:0]       ctrl_o,
  output logic              slip_clr_o,
  output logic              bus_sel_pll_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int CNT_MAX = (RST_HOLD > LOCK_TIMEOUT) ? RST_HOLD : LOCK_TIMEOUT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              rst_meta, rst_n;
  seq_cmd_t          cmd;
  logic              cnt_clr, cnt_inc;
  logic [CNT_W-1:0]  cnt;
  logic              pll_on;
  logic [FACT_W-1:0] fact;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  always_comb begin
    fact   = {bw_adj_i, out_div_i, fb_div_i, ref_div_i};
    pll_on = ctrl_o[BIT_PWR] & ctrl_o[BIT_EN] & ~ctrl_o[BIT_RST];
  end

  pll_seq_fsm #(
    .LOCK_W(LOCK_W), .RST_HOLD(RST_HOLD),
    .LOCK_TIMEOUT(LOCK_TIMEOUT), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_n),
    .req_en_i(req_en_i), .req_dis_i(req_dis_i),
    .pll_on_i(pll_on), .lock_i(lock_i), .cnt_i(cnt),
    .cmd_o(cmd), .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  pll_seq_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n),
    .clr_i(cnt_clr), .inc_i(cnt_inc), .cnt_o(cnt)
  );

  pll_seq_ctrl #(.IS_CPU(IS_CPU)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_n),
    .cmd_i(cmd), .fact_i(fact),
    .ctrl_o(ctrl_o), .bus_sel_o(bus_sel_pll_o), .slip_o(slip_clr_o)
  );

  // R5: a slip strobe only follows a poll that saw a partial lock
  a_r5_slip_on_miss: assert property (@(posedge clk_i) disable iff (!rst_n)
    slip_clr_o |-> !$past(&lock_i));
  // R5: enable rises only after a complete lock was sampled
  a_r5_enable_after_lock: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(ctrl_o[BIT_EN]) |-> $past(&lock_i, 2));
  // R9: a timeout leaves the PLL bypassed and not enabled
  a_r9_err_safe: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(err_o) |-> (ctrl_o[BIT_BYP] && !ctrl_o[BIT_EN]));

  generate
    if (IS_CPU) begin : g_park_chk
      // R3: the bus is parked on the raw input when the PLL output is switched in
      a_r3_parked_on_enable: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(ctrl_o[BIT_EN]) |-> !bus_sel_pll_o);
    end
  endgenerate
endmodule

// File: tb/pll_seq_bench.sv
`timescale 1ns/1ps
module pll_seq_bench;
  localparam int LW = 2;
  localparam int HOLD = 3;
  localparam int TMO = 24;
  localparam int D0 = 6;
  localparam int D1 = 9;
  localparam int P_IDLE = 0, P_PARK = 1, P_PROG = 2, P_RLOW = 3, P_RSET = 4,
                 P_HOLD = 5, P_POLL = 6, P_RUN = 7, P_UNPARK = 8, P_BYP = 9,
                 P_OFF = 10, P_FIN = 11;

  logic clk = 1'b0;
  logic rst_n;
  logic req_en, req_dis;
  logic [3:0] ref_v;
  logic [5:0] fb_v;
  logic [3:0] od_v;
  logic [5:0] bw_v;
  logic [LW-1:0] lock;
  logic [25:0] ctrl_o;
  logic slip_o, bus_o, busy_o, done_o, err_o;

  always #2.5 clk = ~clk;

  pll_seq #(.LOCK_W(LW), .IS_CPU(1'b1), .RST_HOLD(HOLD), .LOCK_TIMEOUT(TMO)) u_pll_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_en_i(req_en), .req_dis_i(req_dis),
    .ref_div_i(ref_v), .fb_div_i(fb_v), .out_div_i(od_v), .bw_adj_i(bw_v),
    .lock_i(lock), .ctrl_o(ctrl_o), .slip_clr_o(slip_o), .bus_sel_pll_o(bus_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  // reference model state
  logic [25:0] e_ctrl;
  logic e_bus, e_busy, e_done, e_slip, e_err;
  int ph, hold, pc;
  // PLL plant
  int lkc;
  bit dead;
  // bookkeeping
  int checks = 0, fails = 0;
  int rst_run = 0, rst_width = 0, slip_seen = 0, slip_exp = 0;
  bit over = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] packf();
    return (20'(bw_v) << 14) | (20'(od_v) << 10) | (20'(fb_v) << 4) | 20'(ref_v);
  endfunction

  task automatic model_step(input logic en, input logic dis);
    logic on;
    e_slip = 1'b0;
    on = e_ctrl[21] && e_ctrl[25] && !e_ctrl[20];
    if (ph == P_IDLE) begin
      if (dis) begin ph = P_BYP; e_err = 1'b0; end
      else if (en && !on) begin ph = P_PARK; e_err = 1'b0; end
    end else begin
      case (ph)
        P_PARK: begin e_bus = 1'b0; ph = P_PROG; end
        P_PROG: begin e_ctrl[19:0] = packf(); e_ctrl[21] = 1'b1; ph = P_RLOW; end
        P_RLOW: begin e_ctrl[20] = 1'b0; ph = P_RSET; end
        P_RSET: begin e_ctrl[20] = 1'b1; hold = 0; ph = P_HOLD; end
        P_HOLD: begin
          hold++;
          if (hold == HOLD) begin e_ctrl[20] = 1'b0; pc = 0; ph = P_POLL; end
        end
        P_POLL: begin
          if (&lock) ph = P_RUN;
          else if (pc == TMO - 1) begin e_err = 1'b1; ph = P_FIN; end
          else begin e_slip = 1'b1; slip_exp++; pc++; end
        end
        P_RUN: begin e_ctrl[23] = 1'b0; e_ctrl[25] = 1'b1; ph = P_UNPARK; end
        P_UNPARK: begin e_bus = 1'b1; ph = P_FIN; end
        P_BYP: begin e_ctrl[23] = 1'b1; ph = P_OFF; end
        P_OFF: begin e_ctrl[21] = 1'b0; e_ctrl[25] = 1'b0; ph = P_FIN; end
        default: ph = P_IDLE;
      endcase
    end
    e_busy = (ph != P_IDLE);
    e_done = (ph == P_FIN);
  endtask

  task automatic tick(input logic en, input logic dis);
    req_en = en;
    req_dis = dis;
    model_step(en, dis);
    @(posedge clk);
    @(negedge clk);
    req_en = 1'b0;
    req_dis = 1'b0;
    chk(ctrl_o == e_ctrl, "R3 control word", 32'(ctrl_o), 32'(e_ctrl));
    chk(bus_o == e_bus, "R3 bus select", 32'(bus_o), 32'(e_bus));
    chk(busy_o == e_busy, "R8 busy", 32'(busy_o), 32'(e_busy));
    chk(done_o == e_done, "R8 done", 32'(done_o), 32'(e_done));
    chk(slip_o == e_slip, "R5 slip clear", 32'(slip_o), 32'(e_slip));
    chk(err_o == e_err, "R9 error", 32'(err_o), 32'(e_err));
    if (slip_o) slip_seen++;
    if (ctrl_o[20]) rst_run++;
    else if (rst_run > 0) begin rst_width = rst_run; rst_run = 0; end
    // plant: lock bits rise at different times after reset release with power on
    if (!ctrl_o[21] || ctrl_o[20]) lkc = 0;
    else if (lkc < 1000) lkc++;
    lock[0] = !dead && (lkc >= D0);
    lock[1] = !dead && (lkc >= D1);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!over) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [25:0] held;
    req_en = 0; req_dis = 0;
    ref_v = 4'd1; fb_v = 6'd39; od_v = 4'd2; bw_v = 6'd39;
    lock = '0; dead = 0; lkc = 0;
    e_ctrl = 26'(1) << 23; e_bus = 0; e_busy = 0; e_done = 0; e_slip = 0; e_err = 0;
    ph = P_IDLE; hold = 0; pc = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctrl_o == (26'(1) << 23), "R1 ctrl reset", 32'(ctrl_o), 32'(1) << 23);
    chk({bus_o, slip_o, busy_o, done_o, err_o} == 5'b0, "R1 flags reset",
        32'({bus_o, slip_o, busy_o, done_o, err_o}), 0);
    rst_n = 1'b1;
    repeat (4) tick(0, 0);

    // first enable; requests mid-sequence are ignored (R10)
    tick(1, 0);
    repeat (8) tick(0, 0);
    tick(1, 1);
    repeat (50) tick(0, 0);
    chk(ctrl_o[19:0] == packf(), "R2 factor fields", 32'(ctrl_o[19:0]), 32'(packf()));
    chk(ctrl_o[25] && !ctrl_o[23] && bus_o, "R3 running", 32'(ctrl_o), 32'(e_ctrl));
    chk(rst_width == HOLD, "R4 reset pulse width", 32'(rst_width), 32'(HOLD));
    chk(slip_seen == slip_exp && slip_exp > 0, "R5 slip pulse count", 32'(slip_seen), 32'(slip_exp));

    // R7: enable while already running is ignored
    held = ctrl_o;
    tick(1, 0);
    chk(!busy_o, "R7 no busy", 32'(busy_o), 0);
    tick(0, 0);
    chk(ctrl_o == held, "R7 ctrl unchanged", 32'(ctrl_o), 32'(held));

    // R6 disable ordering
    tick(0, 1);
    chk(busy_o, "R8 busy on disable", 32'(busy_o), 1);
    tick(0, 0);
    chk(ctrl_o[23] && ctrl_o[21] && ctrl_o[25], "R6 bypass first", 32'(ctrl_o), 32'(e_ctrl));
    tick(0, 0);
    chk(ctrl_o[23] && !ctrl_o[21] && !ctrl_o[25] && bus_o, "R6 power off, bus kept",
        32'({bus_o, ctrl_o}), 32'({e_bus, e_ctrl}));
    chk(done_o, "R8 done at end", 32'(done_o), 1);
    repeat (3) tick(0, 0);

    // R10: simultaneous requests -> disable wins
    tick(1, 1);
    repeat (6) tick(0, 0);
    chk(!ctrl_o[21] && !ctrl_o[25] && !busy_o, "R10 disable wins", 32'(ctrl_o), 32'(e_ctrl));

    // second enable with different factors
    ref_v = 4'd0; fb_v = 6'd22; od_v = 4'd1; bw_v = 6'd22;
    tick(1, 0);
    repeat (50) tick(0, 0);
    chk(ctrl_o[19:0] == packf(), "R2 factor fields B", 32'(ctrl_o[19:0]), 32'(packf()));
    chk(ctrl_o[25], "R3 running B", 32'(ctrl_o), 32'(e_ctrl));

    // R9 lock timeout
    tick(0, 1);
    repeat (6) tick(0, 0);
    dead = 1;
    tick(1, 0);
    repeat (50) tick(0, 0);
    chk(err_o, "R9 error set", 32'(err_o), 1);
    chk(ctrl_o[23] && ctrl_o[21] && !ctrl_o[25] && !bus_o, "R9 safe state",
        32'({bus_o, ctrl_o}), 32'({e_bus, e_ctrl}));
    dead = 0;
    tick(1, 0);
    chk(!err_o, "R9 error cleared on accept", 32'(err_o), 0);
    repeat (50) tick(0, 0);
    chk(ctrl_o[25] && bus_o && !err_o, "R9 recovery", 32'({bus_o, ctrl_o}), 32'({e_bus, e_ctrl}));

    over = 1;
    summary();
    $finish;
  end
endmodule